// File: doc/BRIEF.md
# Radix-4 Butterfly Stage with Scheduled Scaling

This block is one pass of a three-pass, 64-point radix-4 decimation-in-frequency transform engine. Each accepted input carries four complex samples, a pass number, a 3-bit scale code and a direction bit. From these it forms the four radix-4 butterfly outputs at a widened internal precision. It then right-shifts each component by an amount chosen from a fixed schedule, rounding to nearest, and clamps the result back to 12-bit two's complement.

The controller around the block presents one butterfly per cycle with `in_vld` high. It marks the first butterfly of each new block with `blk_first`. Results come out two cycles later with `out_vld` high. The sticky `ovf` flag reports whether any component in the current block had to be clamped. Twiddle multiplication and memory addressing live outside this block.

Top module: `radix4_scaled_bfly`

## Requirements
- R1: With `dir_inv`=0 the outputs are Y0=A+B+C+D, Y1=A-jB-C+jD, Y2=A-B+C-D and Y3=A+jB-C-jD, each computed without loss before scaling.
- R2: With `dir_inv`=1, Y0 and Y2 are unchanged and the sign of every j term flips, so Y1=A+jB-C-jD and Y3=A-jB-C+jD.
- R3: The right shift is taken from `scale_code` (0..7) and `pass_num`. For pass 1 the shifts by code 0..7 are 0,1,1,2,2,2,3,3. For pass 2 they are 0,0,1,1,1,2,2,2. For pass 3 they are 0,0,0,0,1,1,1,2. A `pass_num` of 0 applies no shift. The three passes together shift by exactly the code.
- R4: A non-zero shift of s bits adds 2^(s-1) before an arithmetic right shift, so halves round toward positive infinity (e.g. -3 shifted by 1 gives -1, -1 shifted by 1 gives 0). A zero shift passes the value through unchanged.
- R5: A scaled component above 2047 is output as 2047 and one below -2048 as -2048; both count as an overflow event.
- R6: `ovf` goes high two cycles after an accepted butterfly that has an overflow event. It then stays high for every later butterfly of the same block.
- R7: A butterfly accepted with `blk_first`=1 clears `ovf` when its own result is produced, unless that butterfly itself overflows.
- R8: Latency is fixed at two cycles. `out_vld` equals `in_vld` delayed by two cycles, and one butterfly per cycle is accepted with no bubbles.
- R9: When no valid result is produced, all output data and `ovf` hold their previous values.
- R10: After asynchronous reset (`rst_n` low), `out_vld`, `ovf` and every output component read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Input butterfly valid |
| blk_first | input | 1 | Marks the first butterfly of a new block |
| pass_num | input | 2 | Pass number 1..3 (0 = no shift) |
| scale_code | input | 3 | Total scaling code, 0..7 bits |
| dir_inv | input | 1 | 0 forward, 1 inverse |
| a_re | input | 12 | Sample A real |
| a_im | input | 12 | Sample A imaginary |
| b_re | input | 12 | Sample B real |
| b_im | input | 12 | Sample B imaginary |
| c_re | input | 12 | Sample C real |
| c_im | input | 12 | Sample C imaginary |
| d_re | input | 12 | Sample D real |
| d_im | input | 12 | Sample D imaginary |
| out_vld | output | 1 | Output butterfly valid |
| ovf | output | 1 | Sticky block overflow flag |
| y0_re | output | 12 | Output Y0 real |
| y0_im | output | 12 | Output Y0 imaginary |
| y1_re | output | 12 | Output Y1 real |
| y1_im | output | 12 | Output Y1 imaginary |
| y2_re | output | 12 | Output Y2 real |
| y2_im | output | 12 | Output Y2 imaginary |
| y3_re | output | 12 | Output Y3 real |
| y3_im | output | 12 | Output Y3 imaginary |

## Verification
A wrong shift selection or a wrong rounding offset in the first stage shows as a value error on the data ports exactly two cycles after the affected butterfly. Such errors are often only one LSB, so the vectors include exact half-LSB cases of both signs. A swapped j-term sign shows up only in Y1 and Y3, and only for inputs whose B or D component is non-zero. A stale overflow register or a missed clear shows at `ovf` on the first result of the next block. The valid pipeline is exercised back to back, so a lost or duplicated valid bit appears in the cycle where it occurs.

// File: rtl/radix4_scaled_bfly.sv
module radix4_scaled_bfly #(
  parameter int DW = 12,
  parameter int GW = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  logic                 blk_first,
  input  logic [1:0]           pass_num,
  input  logic [2:0]           scale_code,
  input  logic                 dir_inv,
  input  logic signed [DW-1:0] a_re,
  input  logic signed [DW-1:0] a_im,
  input  logic signed [DW-1:0] b_re,
  input  logic signed [DW-1:0] b_im,
  input  logic signed [DW-1:0] c_re,
  input  logic signed [DW-1:0] c_im,
  input  logic signed [DW-1:0] d_re,
  input  logic signed [DW-1:0] d_im,
  output logic                 out_vld,
  output logic                 ovf,
  output logic signed [DW-1:0] y0_re,
  output logic signed [DW-1:0] y0_im,
  output logic signed [DW-1:0] y1_re,
  output logic signed [DW-1:0] y1_im,
  output logic signed [DW-1:0] y2_re,
  output logic signed [DW-1:0] y2_im,
  output logic signed [DW-1:0] y3_re,
  output logic signed [DW-1:0] y3_im
);
  localparam int IW = DW + GW;
  localparam logic signed [IW-1:0] MAXV = IW'((1 << (DW-1)) - 1);
  localparam logic signed [IW-1:0] MINV = -MAXV - IW'(1);

  logic signed [IW-1:0] ar, ai, br, bi, cr, ci, dr, di;
  assign ar = a_re;  assign ai = a_im;
  assign br = b_re;  assign bi = b_im;
  assign cr = c_re;  assign ci = c_im;
  assign dr = d_re;  assign di = d_im;

  logic signed [IW-1:0] t_re [4];
  logic signed [IW-1:0] t_im [4];
  logic signed [IW-1:0] pr, pi, qr, qi;

  always_comb begin
    pr = ar - cr;
    pi = ai - ci;
    qr = bi - di;
    qi = br - dr;
    t_re[0] = ar + br + cr + dr;
    t_im[0] = ai + bi + ci + di;
    t_re[2] = ar - br + cr - dr;
    t_im[2] = ai - bi + ci - di;
    t_re[1] = dir_inv ? pr - qr : pr + qr;
    t_im[1] = dir_inv ? pi + qi : pi - qi;
    t_re[3] = dir_inv ? pr + qr : pr - qr;
    t_im[3] = dir_inv ? pi - qi : pi + qi;
  end

  function automatic logic [1:0] pick_shift(input logic [1:0] p, input logic [2:0] c);
    case (p)
      2'd1:    return (c < 3'd1) ? 2'd0 : (c < 3'd3) ? 2'd1 : (c < 3'd6) ? 2'd2 : 2'd3;
      2'd2:    return (c < 3'd2) ? 2'd0 : (c < 3'd5) ? 2'd1 : 2'd2;
      2'd3:    return (c < 3'd4) ? 2'd0 : (c < 3'd7) ? 2'd1 : 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  logic signed [IW-1:0] s1_re [4];
  logic signed [IW-1:0] s1_im [4];
  logic [1:0] s1_sh;
  logic s1_vld, s1_first;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) begin
        s1_re[k] <= '0;
        s1_im[k] <= '0;
      end
      s1_sh    <= '0;
      s1_vld   <= 1'b0;
      s1_first <= 1'b0;
    end else begin
      s1_vld <= in_vld;
      if (in_vld) begin
        for (int k = 0; k < 4; k++) begin
          s1_re[k] <= t_re[k];
          s1_im[k] <= t_im[k];
        end
        s1_sh    <= pick_shift(pass_num, scale_code);
        s1_first <= blk_first;
      end
    end
  end

  function automatic logic [DW:0] scale_sat(input logic signed [IW-1:0] v, input logic [1:0] sh);
    logic signed [IW-1:0] half, r;
    half = (sh == 2'd0) ? '0 : (IW'(1) << (sh - 2'd1));
    r = v + half;
    r = r >>> sh;
    if (r > MAXV)      return {1'b1, MAXV[DW-1:0]};
    else if (r < MINV) return {1'b1, MINV[DW-1:0]};
    else               return {1'b0, r[DW-1:0]};
  endfunction

  logic [DW:0] n_re [4];
  logic [DW:0] n_im [4];
  logic [7:0]  lane_ovf;
  logic        ovf_hit;

  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign n_re[g] = scale_sat(s1_re[g], s1_sh);
    assign n_im[g] = scale_sat(s1_im[g], s1_sh);
    assign lane_ovf[2*g]   = n_re[g][DW];
    assign lane_ovf[2*g+1] = n_im[g][DW];
  end
  assign ovf_hit = |lane_ovf;

  logic signed [DW-1:0] y_re [4];
  logic signed [DW-1:0] y_im [4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) begin
        y_re[k] <= '0;
        y_im[k] <= '0;
      end
      out_vld <= 1'b0;
      ovf     <= 1'b0;
    end else begin
      out_vld <= s1_vld;
      if (s1_vld) begin
        for (int k = 0; k < 4; k++) begin
          y_re[k] <= n_re[k][DW-1:0];
          y_im[k] <= n_im[k][DW-1:0];
        end
        ovf <= (ovf & ~s1_first) | ovf_hit;
      end
    end
  end

  assign y0_re = y_re[0];  assign y0_im = y_im[0];
  assign y1_re = y_re[1];  assign y1_im = y_im[1];
  assign y2_re = y_re[2];  assign y2_im = y_im[2];
  assign y3_re = y_re[3];  assign y3_im = y_im[3];
endmodule

// File: rtl/radix4_scaled_bfly_chk.sv
module radix4_scaled_bfly_chk #(
  parameter int DW = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_vld,
  input logic                 out_vld,
  input logic                 ovf,
  input logic                 s1_vld,
  input logic                 s1_first,
  input logic                 ovf_hit,
  input logic signed [DW-1:0] y0_re,
  input logic signed [DW-1:0] y3_im
);
  // R8
  lat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n) in_vld |=> ##1 out_vld);
  // R8
  lat_lo_chk: assert property (@(posedge clk) disable iff (!rst_n) !in_vld |=> ##1 !out_vld);
  // R9
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_vld |=> ($stable(y0_re) && $stable(y3_im) && $stable(ovf)));
  // R6
  sticky_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !(s1_vld && s1_first)) |=> ovf);
  // R5
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && ovf_hit) |=> ovf);
  // R7
  ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && s1_first && !ovf_hit) |=> !ovf);
endmodule

bind radix4_scaled_bfly radix4_scaled_bfly_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .out_vld(out_vld), .ovf(ovf),
  .s1_vld(s1_vld), .s1_first(s1_first), .ovf_hit(ovf_hit),
  .y0_re(y0_re), .y3_im(y3_im)
);

// File: tb/tb_radix4_scaled_bfly.sv
module tb_radix4_scaled_bfly;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_vld = 1'b0, blk_first = 1'b0, dir_inv = 1'b0;
  logic [1:0] pass_num = '0;
  logic [2:0] scale_code = '0;
  logic signed [11:0] xr [4];
  logic signed [11:0] xi [4];
  logic out_vld, ovf;
  logic signed [11:0] yr [4];
  logic signed [11:0] yi [4];
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  radix4_scaled_bfly dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .blk_first(blk_first),
    .pass_num(pass_num), .scale_code(scale_code), .dir_inv(dir_inv),
    .a_re(xr[0]), .a_im(xi[0]), .b_re(xr[1]), .b_im(xi[1]),
    .c_re(xr[2]), .c_im(xi[2]), .d_re(xr[3]), .d_im(xi[3]),
    .out_vld(out_vld), .ovf(ovf),
    .y0_re(yr[0]), .y0_im(yi[0]), .y1_re(yr[1]), .y1_im(yi[1]),
    .y2_re(yr[2]), .y2_im(yi[2]), .y3_re(yr[3]), .y3_im(yi[3])
  );

  localparam int NV = 14;
  // a_re a_im b_re b_im c_re c_im d_re d_im pass scale inv
  localparam int VEC [NV][11] = '{
    '{100, -50, 20, 30, -7, 8, 1, -1, 1, 0, 0},
    '{100, -50, 20, 30, -7, 8, 1, -1, 1, 0, 1},
    '{2047, 2047, 2047, 2047, 2047, 2047, 2047, 2047, 1, 0, 0},
    '{2047, 2047, 2047, 2047, 2047, 2047, 2047, 2047, 1, 7, 0},
    '{-2048, -2048, -2048, -2048, -2048, -2048, -2048, -2048, 2, 5, 1},
    '{3, -3, 0, 0, 0, 0, 0, 0, 1, 1, 0},
    '{6, -6, 0, 0, 0, 0, 0, 0, 3, 7, 0},
    '{2047, 0, 2047, 0, 0, 0, 0, 0, 1, 1, 0},
    '{2047, 0, 1, 0, 0, 0, 0, 0, 1, 0, 0},
    '{500, -300, -200, 100, 50, 60, -70, 80, 2, 2, 1},
    '{500, -300, -200, 100, 50, 60, -70, 80, 3, 3, 0},
    '{900, 900, -900, 900, 900, -900, -900, -900, 0, 7, 1},
    '{1000, -1000, 1000, -1000, 1000, -1000, 1000, -1000, 2, 6, 0},
    '{-1, -1, 0, 0, 0, 0, 0, 0, 3, 4, 0}
  };
  localparam int SHT [3][8] = '{
    '{0, 1, 1, 2, 2, 2, 3, 3},
    '{0, 0, 1, 1, 1, 2, 2, 2},
    '{0, 0, 0, 0, 1, 1, 1, 2}
  };

  int er [4];
  int ei [4];
  bit eov;

  function automatic int scl(input int v, input int sh, inout bit o);
    int r;
    r = (sh == 0) ? v : ((v + (1 << (sh - 1))) >>> sh);
    if (r > 2047) begin o = 1'b1; return 2047; end
    if (r < -2048) begin o = 1'b1; return -2048; end
    return r;
  endfunction

  task automatic model(input int v [11]);
    int ar, ai, br, bi, cr, ci, dr, di, sh;
    int f1r, f1i, f3r, f3i;
    ar = v[0]; ai = v[1]; br = v[2]; bi = v[3];
    cr = v[4]; ci = v[5]; dr = v[6]; di = v[7];
    sh = (v[8] == 0) ? 0 : SHT[v[8]-1][v[9]];
    // forward: Y1 = A - jB - C + jD, Y3 = A + jB - C - jD
    f1r = ar + bi - cr - di;  f1i = ai - br - ci + dr;
    f3r = ar - bi - cr + di;  f3i = ai + br - ci - dr;
    eov = 1'b0;
    er[0] = scl(ar + br + cr + dr, sh, eov);
    ei[0] = scl(ai + bi + ci + di, sh, eov);
    er[2] = scl(ar - br + cr - dr, sh, eov);
    ei[2] = scl(ai - bi + ci - di, sh, eov);
    er[1] = scl(v[10] != 0 ? f3r : f1r, sh, eov);
    ei[1] = scl(v[10] != 0 ? f3i : f1i, sh, eov);
    er[3] = scl(v[10] != 0 ? f1r : f3r, sh, eov);
    ei[3] = scl(v[10] != 0 ? f1i : f3i, sh, eov);
  endtask

  task automatic drive(input int v [11], input bit first);
    for (int k = 0; k < 4; k++) begin
      xr[k] = 12'(v[2*k]);
      xi[k] = 12'(v[2*k+1]);
    end
    pass_num = 2'(v[8]);
    scale_code = 3'(v[9]);
    dir_inv = v[10] != 0;
    blk_first = first;
    in_vld = 1'b1;
  endtask

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic chk_data(input string tag);
    for (int k = 0; k < 4; k++) begin
      chk(tag, int'(yr[k]), er[k]);
      chk(tag, int'(yi[k]), ei[k]);
    end
  endtask

  task automatic run_one(input int v [11], input bit first);
    drive(v, first);
    @(negedge clk);
    in_vld = 1'b0;
    blk_first = 1'b0;
    chk("R8 no result after one cycle", int'(out_vld), 0);
    @(negedge clk);
    chk("R8 out_vld after two cycles", int'(out_vld), 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog got=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int idle [11];
    for (int k = 0; k < 4; k++) begin xr[k] = '0; xi[k] = '0; end
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 out_vld", int'(out_vld), 0);
    chk("R10 ovf", int'(ovf), 0);
    for (int k = 0; k < 4; k++) begin
      chk("R10 y_re", int'(yr[k]), 0);
      chk("R10 y_im", int'(yi[k]), 0);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R4 R5 table walk, each vector starting its own block (R7)
    for (int n = 0; n < NV; n++) begin
      model(VEC[n]);
      run_one(VEC[n], 1'b1);
      chk_data("R1 R2 R3 R4 R5 vector data");
      chk("R5 R7 vector ovf", int'(ovf), int'(eov));
    end

    // R6 sticky: overflow vector then clean vector in same block
    model(VEC[2]);
    run_one(VEC[2], 1'b1);
    chk("R6 ovf set", int'(ovf), 1);
    model(VEC[0]);
    run_one(VEC[0], 1'b0);
    chk_data("R6 clean data");
    chk("R6 ovf held", int'(ovf), 1);
    // R7 new block with clean vector clears
    run_one(VEC[0], 1'b1);
    chk("R7 ovf cleared", int'(ovf), 0);

    // R9 idle inputs change, outputs hold
    idle = VEC[4];
    for (int k = 0; k < 4; k++) begin
      xr[k] = 12'(idle[2*k]);
      xi[k] = 12'(idle[2*k+1]);
    end
    blk_first = 1'b1;
    repeat (3) @(negedge clk);
    blk_first = 1'b0;
    chk("R9 out_vld low", int'(out_vld), 0);
    chk_data("R9 data held");
    chk("R9 ovf held", int'(ovf), 0);

    // R8 back-to-back stream
    for (int i = 0; i < 6; i++) begin
      if (i >= 2) begin
        model(VEC[i + 3]);
        chk("R8 stream valid", int'(out_vld), 1);
        chk_data("R8 stream data");
      end
      if (i < 4) drive(VEC[i + 5], 1'b0);
      else in_vld = 1'b0;
      @(negedge clk);
    end
    chk("R8 stream end", int'(out_vld), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule